// File: doc/BRIEF.md
# PS/2 Keyboard Command Transmitter

This block sends a command from the host side of a PS/2 link to an attached keyboard. The client hands over one command byte on a valid/ready handshake. The block first claims the bus by holding the clock line low. It then places the start bit on the data line and releases the clock. After that it presents one bit per clock cycle that the keyboard generates. Both bus lines are open-collector, so the block never drives a high level. Its two outputs only say whether to pull a line low. The pad logic outside the block turns them into tristate controls, and the levels it reads back from the wire enter on two inputs.

Every frame holds a start bit, eight data bits with the least significant bit first, an odd parity bit and a stop bit. The keyboard answers with an acknowledge bit, which the block samples. The lock-LED command (0xED) needs a second byte. For that command the block waits until the receive path reports the keyboard's 0xFA acceptance byte. It then sends a second frame that carries the three LED states. If the keyboard stops clocking, or never answers, the block gives up after a timeout and releases both lines. Each transaction ends with a one-cycle completion pulse and a result code.

Top module: `ps2_cmd_tx`

## Requirements
- R1: `reqReady` is high only while no transaction is in progress. A request is taken on a cycle where `reqValid` and `reqReady` are both high. `reqReady` then stays low until the completion pulse.
- R2: After a request is taken, `ps2ClkOe` is asserted for at least INHIBIT_CYC clock cycles before `ps2DatOe` is asserted.
- R3: The start bit (`ps2DatOe` high) is applied while the clock is still held low. The clock is released only while the start bit is present.
- R4: After each falling edge of the device clock, the block presents the next bit: data bits 0 to 7, then the odd parity bit (1 when the byte has an even number of ones), then a stop bit of 1, which means the data line is released.
- R5: On the eleventh falling edge the data line is sampled as the acknowledge bit. A low level means success. A high level ends the transaction with result code 1 (NACK).
- R6: When the command byte is 0xED and its frame was acknowledged, the block waits for `rxValid` with `rxByte` = 0xFA. It then sends a second frame whose byte has bit 2 = Caps Lock (`reqLeds[2]`), bit 1 = Num Lock (`reqLeds[1]`), bit 0 = Scroll Lock (`reqLeds[0]`), and bits 7..3 zero. Any other command ends after one frame.
- R7: A reply byte other than 0xFA while waiting for the acceptance byte ends the transaction with result code 3 (BADREPLY). No second frame is sent.
- R8: If TIMEOUT_CYC cycles pass without a device clock edge while a frame is being sent, or without the acceptance byte while waiting for it, the transaction ends with result code 2 (TIMEOUT) and both lines are released.
- R9: The block only pulls lines low. When idle, both `ps2ClkOe` and `ps2DatOe` are low.
- R10: `doneValid` is a single-cycle pulse, and `doneCode` is valid with it. Codes are 0 for success, 1 for NACK, 2 for TIMEOUT and 3 for BADREPLY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command request present |
| reqReady | output | 1 | Block can take a request |
| reqCmd | input | 8 | Command byte |
| reqLeds | input | 3 | LED states for 0xED: {caps, num, scroll} |
| rxValid | input | 1 | Receive path delivers a byte |
| rxByte | input | 8 | Byte from the receive path |
| ps2ClkIn | input | 1 | Level seen on the clock line |
| ps2DatIn | input | 1 | Level seen on the data line |
| ps2ClkOe | output | 1 | Pull the clock line low |
| ps2DatOe | output | 1 | Pull the data line low |
| doneValid | output | 1 | Transaction finished (one cycle) |
| doneCode | output | 2 | Result code, valid with doneValid |

## Verification
The hardest case to reach from the ports is a two-byte LED command whose second stage goes wrong. The first frame must be clocked and acknowledged correctly before the block waits for the reply. Only then can a wrong reply, a missing reply or a missing second acknowledge be injected. The bench models the keyboard on the wired-AND lines. It clocks each frame, captures the bits and chooses per frame whether to acknowledge. Random transactions mix reply bytes, acknowledge outcomes and LED patterns, and directed cases add a keyboard that never clocks and one that never replies.

// File: rtl/ps2_cmd_pkg.sv
package ps2_cmd_pkg;

  localparam logic [7:0] CMD_SET_LEDS = 8'hED;
  localparam logic [7:0] RSP_ACCEPT   = 8'hFA;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic loadCmd;
    logic loadArg;
    logic shift;
    logic clkHold;
    logic frameOn;
  } ctlStb_t;

  // conditions from datapath to control
  typedef struct packed {
    logic clkFall;
    logic clkHigh;
    logic datHigh;
    logic tmrInhDone;
    logic tmrSetupDone;
    logic tmrExpired;
  } dpFlags_t;

  typedef enum logic [1:0] {
    DC_OK       = 2'd0,
    DC_NACK     = 2'd1,
    DC_TIMEOUT  = 2'd2,
    DC_BADREPLY = 2'd3
  } doneCode_e;

endpackage

// File: rtl/ps2_cmd_dp.sv
module ps2_cmd_dp
  import ps2_cmd_pkg::*;
#(
  parameter int INHIBIT_CYC = 5000,
  parameter int SETUP_CYC   = 250,
  parameter int TIMEOUT_CYC = 750000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStb_t    stb,
  input  logic [7:0] reqCmd,
  input  logic [2:0] reqLeds,
  input  logic       ps2ClkIn,
  input  logic       ps2DatIn,
  output dpFlags_t   flags,
  output logic       ps2ClkOe,
  output logic       ps2DatOe
);

  localparam int MAX_A = (INHIBIT_CYC > SETUP_CYC) ? INHIBIT_CYC : SETUP_CYC;
  localparam int MAX_C = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
  localparam int TW    = $clog2(MAX_C + 1);
  localparam int FW    = 10; // data + parity + stop

  logic [SYNC_STAGES-1:0] clkChain, datChain;
  logic                   clkPrev;
  logic [TW-1:0]          tmr;
  logic [7:0]             argReg;
  logic [FW-1:0]          shReg;
  logic                   txLevel;

  // input synchronisers
  generate
    if (SYNC_STAGES == 1) begin : g_syncOne
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkChain <= '1;
          datChain <= '1;
        end else begin
          clkChain <= ps2ClkIn;
          datChain <= ps2DatIn;
        end
      end
    end else begin : g_syncMany
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkChain <= '1;
          datChain <= '1;
        end else begin
          clkChain <= {clkChain[SYNC_STAGES-2:0], ps2ClkIn};
          datChain <= {datChain[SYNC_STAGES-2:0], ps2DatIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= clkChain[SYNC_STAGES-1];
  end

  // shared interval timer
  always_ff @(posedge clk) begin
    if (!rstN)                  tmr <= '0;
    else if (stb.tmrClr)        tmr <= '0;
    else if (tmr != TW'(MAX_C)) tmr <= tmr + 1'b1;
  end

  // frame shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      argReg  <= '0;
      shReg   <= '1;
      txLevel <= 1'b1;
    end else if (stb.loadCmd) begin
      argReg  <= {5'b0, reqLeds};
      shReg   <= {1'b1, ~^reqCmd, reqCmd};
      txLevel <= 1'b0;
    end else if (stb.loadArg) begin
      shReg   <= {1'b1, ~^argReg, argReg};
      txLevel <= 1'b0;
    end else if (stb.shift) begin
      txLevel <= shReg[0];
      shReg   <= {1'b1, shReg[FW-1:1]};
    end
  end

  // registered pad enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ps2ClkOe <= 1'b0;
      ps2DatOe <= 1'b0;
    end else begin
      ps2ClkOe <= stb.clkHold;
      ps2DatOe <= stb.frameOn & ~txLevel;
    end
  end

  always_comb begin
    flags.clkFall      = clkPrev & ~clkChain[SYNC_STAGES-1];
    flags.clkHigh      = clkChain[SYNC_STAGES-1];
    flags.datHigh      = datChain[SYNC_STAGES-1];
    flags.tmrInhDone   = (tmr >= TW'(INHIBIT_CYC - 1));
    flags.tmrSetupDone = (tmr >= TW'(SETUP_CYC - 1));
    flags.tmrExpired   = (tmr >= TW'(TIMEOUT_CYC - 1));
  end

endmodule

// File: rtl/ps2_cmd_ctl.sv
module ps2_cmd_ctl
  import ps2_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [7:0] reqCmd,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  dpFlags_t   flags,
  output ctlStb_t    stb,
  output logic       doneValid,
  output logic [1:0] doneCode
);

  typedef enum logic [2:0] {
    S_IDLE, S_INHIBIT, S_START, S_SHIFT, S_TAIL, S_REPLY
  } state_e;

  localparam logic [3:0] LAST_EDGE = 4'd10;

  state_e    state, nextState;
  logic [3:0] bitCnt;
  logic      isLed, onArg, ackOk;
  logic      finish;
  doneCode_e finCode;

  assign reqReady = (state == S_IDLE);

  always_comb begin
    stb       = '0;
    nextState = state;
    finish    = 1'b0;
    finCode   = DC_OK;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.loadCmd = 1'b1;
          stb.tmrClr  = 1'b1;
          nextState   = S_INHIBIT;
        end
      end
      S_INHIBIT: begin
        stb.clkHold = 1'b1;
        if (flags.tmrInhDone) begin
          stb.tmrClr = 1'b1;
          nextState  = S_START;
        end
      end
      S_START: begin
        stb.clkHold = 1'b1;
        stb.frameOn = 1'b1;
        if (flags.tmrSetupDone) begin
          stb.tmrClr = 1'b1;
          nextState  = S_SHIFT;
        end
      end
      S_SHIFT: begin
        stb.frameOn = 1'b1;
        if (flags.clkFall) begin
          stb.shift  = 1'b1;
          stb.tmrClr = 1'b1;
          if (bitCnt == LAST_EDGE) nextState = S_TAIL;
        end else if (flags.tmrExpired) begin
          finish    = 1'b1;
          finCode   = DC_TIMEOUT;
          nextState = S_IDLE;
        end
      end
      S_TAIL: begin
        if (flags.clkHigh && flags.datHigh) begin
          stb.tmrClr = 1'b1;
          if (!ackOk) begin
            finish    = 1'b1;
            finCode   = DC_NACK;
            nextState = S_IDLE;
          end else if (isLed && !onArg) begin
            nextState = S_REPLY;
          end else begin
            finish    = 1'b1;
            finCode   = DC_OK;
            nextState = S_IDLE;
          end
        end else if (flags.tmrExpired) begin
          finish    = 1'b1;
          finCode   = DC_TIMEOUT;
          nextState = S_IDLE;
        end
      end
      S_REPLY: begin
        if (rxValid) begin
          if (rxByte == RSP_ACCEPT) begin
            stb.loadArg = 1'b1;
            stb.tmrClr  = 1'b1;
            nextState   = S_INHIBIT;
          end else begin
            finish    = 1'b1;
            finCode   = DC_BADREPLY;
            nextState = S_IDLE;
          end
        end else if (flags.tmrExpired) begin
          finish    = 1'b1;
          finCode   = DC_TIMEOUT;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      isLed     <= 1'b0;
      onArg     <= 1'b0;
      ackOk     <= 1'b0;
      doneValid <= 1'b0;
      doneCode  <= DC_OK;
    end else begin
      state     <= nextState;
      doneValid <= finish;
      if (finish) doneCode <= finCode;
      if (stb.loadCmd) begin
        isLed  <= (reqCmd == CMD_SET_LEDS);
        onArg  <= 1'b0;
        bitCnt <= '0;
      end else if (stb.loadArg) begin
        onArg  <= 1'b1;
        bitCnt <= '0;
      end else if (stb.shift) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST_EDGE) ackOk <= ~flags.datHigh;
      end
    end
  end

endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
  import ps2_cmd_pkg::*;
#(
  parameter int INHIBIT_CYC = 5000,
  parameter int SETUP_CYC   = 250,
  parameter int TIMEOUT_CYC = 750000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [7:0] reqCmd,
  input  logic [2:0] reqLeds,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       ps2ClkIn,
  input  logic       ps2DatIn,
  output logic       ps2ClkOe,
  output logic       ps2DatOe,
  output logic       doneValid,
  output logic [1:0] doneCode
);

  ctlStb_t  stb;
  dpFlags_t flags;

  ps2_cmd_ctl i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .reqCmd    (reqCmd),
    .rxValid   (rxValid),
    .rxByte    (rxByte),
    .flags     (flags),
    .stb       (stb),
    .doneValid (doneValid),
    .doneCode  (doneCode)
  );

  ps2_cmd_dp #(
    .INHIBIT_CYC (INHIBIT_CYC),
    .SETUP_CYC   (SETUP_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqCmd   (reqCmd),
    .reqLeds  (reqLeds),
    .ps2ClkIn (ps2ClkIn),
    .ps2DatIn (ps2DatIn),
    .flags    (flags),
    .ps2ClkOe (ps2ClkOe),
    .ps2DatOe (ps2DatOe)
  );

endmodule

// File: rtl/ps2_cmd_chk.sv
module ps2_cmd_chk #(
  parameter int INHIBIT_CYC = 5000
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       ps2ClkOe,
  input logic       ps2DatOe,
  input logic       doneValid,
  input logic [1:0] doneCode
);

  logic [31:0] holdCnt;

  // cycles the clock has been held with data still released
  always_ff @(posedge clk) begin
    if (!rstN)                      holdCnt <= '0;
    else if (ps2ClkOe && !ps2DatOe) holdCnt <= (holdCnt == '1) ? holdCnt : holdCnt + 1'b1;
    else if (!ps2ClkOe)             holdCnt <= '0;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady); // R1

  AST_HOLD_BEFORE_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ps2DatOe) && ps2ClkOe |-> holdCnt >= 32'(INHIBIT_CYC)); // R2

  AST_RELEASE_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ps2ClkOe) |-> ps2DatOe); // R3

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && $past(reqReady) |-> !ps2ClkOe && !ps2DatOe); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R10

  AST_DONE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> reqReady && !$isunknown(doneCode)); // R10

endmodule

bind ps2_cmd_tx ps2_cmd_chk #(.INHIBIT_CYC(INHIBIT_CYC)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .ps2ClkOe  (ps2ClkOe),
  .ps2DatOe  (ps2DatOe),
  .doneValid (doneValid),
  .doneCode  (doneCode)
);

// File: tb/test_ps2_cmd_tx.sv
module test_ps2_cmd_tx;

  localparam int INH  = 40;
  localparam int SETC = 4;
  localparam int TMO  = 600;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [7:0] reqCmd = '0;
  logic [2:0] reqLeds = '0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       ps2ClkIn, ps2DatIn, ps2ClkOe, ps2DatOe;
  logic       doneValid;
  logic [1:0] doneCode;
  logic       devClkLow = 1'b0;
  logic       devDatLow = 1'b0;

  int         total = 0;
  int         bad = 0;
  int         doneCnt = 0;
  logic [1:0] lastCode = '0;

  always #10 clk = ~clk;

  assign ps2ClkIn = ~(ps2ClkOe | devClkLow);
  assign ps2DatIn = ~(ps2DatOe | devDatLow);

  ps2_cmd_tx #(
    .INHIBIT_CYC (INH),
    .SETUP_CYC   (SETC),
    .TIMEOUT_CYC (TMO),
    .SYNC_STAGES (2)
  ) i_ps2_cmd_tx (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqLeds(reqLeds), .rxValid(rxValid), .rxByte(rxByte),
    .ps2ClkIn(ps2ClkIn), .ps2DatIn(ps2DatIn), .ps2ClkOe(ps2ClkOe),
    .ps2DatOe(ps2DatOe), .doneValid(doneValid), .doneCode(doneCode)
  );

  always @(negedge clk) begin
    if (doneValid) begin
      doneCnt  <= doneCnt + 1;
      lastCode <= doneCode;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expCode(input logic [7:0] cmd, input bit nack1, input bit nack2,
                                         input logic [7:0] reply);
    if (nack1)        return 2'd1;
    if (cmd != 8'hED) return 2'd0;
    if (reply != 8'hFA) return 2'd3;
    return nack2 ? 2'd1 : 2'd0;
  endfunction

  task automatic wait_done(input int base);
    int g = 0;
    while (doneCnt == base && g < 5000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  // keyboard model: receives one host frame, acknowledges unless nack
  task automatic dev_frame(input bit nack, output logic [9:0] bits);
    int cnt = 0;
    int g = 0;
    bits = '0;
    while (!ps2ClkOe && g < 3000) begin @(negedge clk); g++; end
    while (ps2ClkOe && !ps2DatOe && cnt < 3000) begin @(negedge clk); cnt++; end
    check(cnt >= INH, "R2 hold length", cnt, INH);
    check(ps2ClkOe && ps2DatOe, "R3 start under hold", {ps2ClkOe, ps2DatOe}, 2'b11);
    g = 0;
    while (ps2ClkOe && g < 3000) begin @(negedge clk); g++; end
    check(ps2DatOe == 1'b1, "R3 start after release", ps2DatOe, 1);
    for (int k = 1; k <= 11; k++) begin
      repeat (HALF) @(negedge clk);
      devClkLow = 1'b1;
      if (k == 11 && !nack) devDatLow = 1'b1;
      repeat (HALF) @(negedge clk);
      if (k <= 10) bits[k-1] = ps2DatIn;
      devClkLow = 1'b0;
    end
    devDatLow = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_req(input logic [7:0] cmd, input logic [2:0] leds);
    @(negedge clk);
    reqValid = 1'b1;
    reqCmd   = cmd;
    reqLeds  = leds;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R1 busy after accept", reqReady, 0);
  endtask

  task automatic run_txn(input logic [7:0] cmd, input logic [2:0] leds, input bit nack1,
                         input bit nack2, input logic [7:0] reply);
    logic [9:0] got;
    logic [7:0] argExp;
    int base = doneCnt;
    send_req(cmd, leds);
    dev_frame(nack1, got);
    check(got[7:0] == cmd, "R4 command bits", got[7:0], cmd);
    check(got[8] == ~^cmd, "R4 odd parity", got[8], ~^cmd);
    check(got[9] == 1'b1, "R4 stop bit", got[9], 1);
    if (!nack1 && cmd == 8'hED) begin
      repeat (10) @(negedge clk);
      check(doneCnt == base, "R6 no finish before reply", doneCnt, base);
      rxValid = 1'b1;
      rxByte  = reply;
      @(negedge clk);
      rxValid = 1'b0;
      if (reply == 8'hFA) begin
        argExp = {5'b0, leds};
        dev_frame(nack2, got);
        check(got[7:0] == argExp, "R6 LED byte", got[7:0], argExp);
        check(got[8] == ~^argExp, "R6 LED parity", got[8], ~^argExp);
      end
    end
    wait_done(base);
    check(lastCode == expCode(cmd, nack1, nack2, reply), "R10 result code", lastCode,
          expCode(cmd, nack1, nack2, reply));
    if (nack1) check(lastCode == 2'd1, "R5 nack reported", lastCode, 1);
    if (!nack1 && cmd == 8'hED && reply != 8'hFA)
      check(lastCode == 2'd3, "R7 bad reply", lastCode, 3);
    repeat (3) @(negedge clk);
    check(!ps2ClkOe && !ps2DatOe && reqReady, "R9 lines free after",
          {reqReady, ps2ClkOe, ps2DatOe}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    check(reqReady == 1'b1, "R1 ready in reset", reqReady, 1);
    check(!ps2ClkOe && !ps2DatOe, "R9 released in reset", {ps2ClkOe, ps2DatOe}, 0);
    check(doneValid == 1'b0, "R10 no done in reset", doneValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // directed cases
    run_txn(8'hED, 3'b100, 0, 0, 8'hFA);  // R6 caps only
    run_txn(8'hED, 3'b001, 0, 0, 8'hFA);  // R6 scroll only
    run_txn(8'hED, 3'b010, 0, 1, 8'hFA);  // R5 nack on second byte
    run_txn(8'hEE, 3'b111, 0, 0, 8'hFA);  // R6 single byte
    run_txn(8'hFF, 3'b000, 1, 0, 8'hFA);  // R5 nack
    run_txn(8'hED, 3'b111, 1, 0, 8'hFA);  // R5 nack first byte of ED
    run_txn(8'hED, 3'b101, 0, 0, 8'hFE);  // R7 wrong reply

    // R8: device never clocks
    base = doneCnt;
    send_req(8'hF3, 3'b000);
    wait_done(base);
    check(lastCode == 2'd2, "R8 no clock timeout", lastCode, 2);
    repeat (3) @(negedge clk);
    check(!ps2ClkOe && !ps2DatOe, "R8 lines released", {ps2ClkOe, ps2DatOe}, 0);

    // R8: reply never arrives
    begin
      logic [9:0] got;
      base = doneCnt;
      send_req(8'hED, 3'b110);
      dev_frame(0, got);
      wait_done(base);
      check(lastCode == 2'd2, "R8 no reply timeout", lastCode, 2);
    end

    // constrained random mix
    for (int n = 0; n < 20; n++) begin
      logic [7:0] cmd;
      logic [7:0] rep;
      int sel = int'($urandom % 6);
      case (sel)
        0, 1: cmd = 8'hED;
        2:    cmd = 8'hEE;
        3:    cmd = 8'hF3;
        4:    cmd = 8'hFE;
        default: begin
          cmd = 8'($urandom);
          if (cmd == 8'hED) cmd = 8'hFF;
        end
      endcase
      rep = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFA;
      run_txn(cmd, 3'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0, rep);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule